// File: doc/BRIEF.md
# Main Oscillator Switch with Crystal Presence Detection

This block picks the source of a chip's main clock. The source is either an internal fast RC oscillator, which is always the default, or an external fast crystal oscillator. Software brings the crystal up in a fixed order. First the master clock is parked on the slow clock and its ready flag is seen high. Next the crystal is enabled with a startup time, measured in units of eight slow-clock cycles. After the crystal-ready flag rises, software writes the source-select bit. The select bit reads back at once. The presence flag tells whether a working crystal is actually connected.

The presence flag comes from activity detection, not from the select bit. A toggle flop running on the crystal clock is brought into the slow-clock domain through a synchronizer. The crystal counts as present only if at least two of its edges arrive within a short window of slow-clock cycles. So the select bit can read back as crystal while the presence flag stays low, which means no crystal is fitted or it runs too slowly. The main clock moves to the crystal only after presence is confirmed. The move goes through a break-before-make clock mux, so the output never carries a runt pulse. Clearing the crystal enable drops the ready and presence flags on the next slow edge.

Top module: `osc_main_switch`

## Requirements
- R1: After reset, mck_ready is 1 and xtal_ready, src_xtal_rb and xtal_present are 0. main_clk follows rc_clk.
- R2: mck_ready falls on the first slow edge that samples a new value of mck_from_main. It rises again MCK_LAT (2) slow edges later.
- R3: A crystal start is accepted only on a slow edge where rc_enable is 1, the registered master-clock select is 0 (the slow clock) and mck_ready is 1. Until then xtal_enable only waits.
- R4: xtal_ready rises exactly 8 × xtal_startup slow edges after the accepting edge. A startup value of 0 sets it on the accepting edge itself.
- R5: src_xtal_rb takes the value of src_xtal one slow edge after src_xtal is written.
- R6: Once src_xtal_rb and xtal_ready are both 1, a detection window of 4 slow cycles opens on the next edge. xtal_present is decided on the window's last edge and is 1 if two or more synchronized crystal edges arrived. With the crystal already ready, this is the sixth slow edge after src_xtal is written.
- R7: If the crystal clock is stopped, or makes fewer than two edges in the window, xtal_present stays 0 while src_xtal_rb reads 1.
- R8: Writing src_xtal to 0 clears xtal_present on the second slow edge after the write.
- R9: On the first slow edge that samples xtal_enable at 0, xtal_ready and xtal_present are both cleared.
- R10: main_clk follows xtal_clk while xtal_present is 1 and follows rc_clk otherwise. The two source enables of the mux are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock; all control logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| rc_clk | input | 1 | Fast RC oscillator clock |
| xtal_clk | input | 1 | Fast crystal oscillator clock (may be stopped) |
| rc_enable | input | 1 | RC oscillator is enabled |
| mck_from_main | input | 1 | Master clock source: 0 slow clock, 1 main clock |
| mck_ready | output | 1 | Master clock switch has settled |
| xtal_enable | input | 1 | Crystal oscillator enable |
| xtal_startup | input | SUT_W | Startup time in units of 8 slow cycles |
| src_xtal | input | 1 | Main clock source select: 1 crystal |
| xtal_ready | output | 1 | Crystal startup period has ended |
| src_xtal_rb | output | 1 | Read-back of the source select |
| xtal_present | output | 1 | Crystal activity confirmed; main clock is on the crystal |
| main_clk | output | 1 | Glitch-free main clock |

## Verification
Every result has a fixed latency in slow edges, counted from the edge that first samples a stimulus. The bench drives inputs on falling edges and samples 1 ns after rising edges, so each check lands on a known edge. Read-back is due one edge after a write. Master-clock ready drops on that first edge and returns two edges later. Crystal ready is due 8 × startup edges after acceptance, and presence is due six edges after the select write. The bench checks each flag on the edge before its due edge as well as on the due edge. The clock mux has no fixed slow-edge latency, so main_clk is compared with the expected source only after ten settling cycles, at instants that avoid both oscillators' edges.

// File: rtl/osc_pkg.sv
package osc_pkg;

    // Presence detector sequencing
    typedef enum logic [1:0] {
        DET_IDLE   = 2'd0,
        DET_WINDOW = 2'd1,
        DET_DONE   = 2'd2
    } det_state_t;

    // Defaults shared by the block and its bench
    localparam int DEF_SUT_W      = 8;
    localparam int DEF_UNIT_SHIFT = 3;
    localparam int DEF_MCK_LAT    = 2;
    localparam int DEF_WIN        = 4;
    localparam int DEF_NEED       = 2;
    localparam int DEF_SYNC       = 2;

    // Counter width holding values 0..n-1, at least one bit
    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/osc_mck_ready.sv
module osc_mck_ready
    import osc_pkg::*;
#(
    parameter int LAT = DEF_MCK_LAT
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_in,
    output logic sel_q,
    output logic rdy
);
    localparam int CW = cnt_w(LAT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            rdy   <= 1'b1;
            cnt   <= '0;
        end else if (sel_in != sel_q) begin
            sel_q <= sel_in;
            rdy   <= 1'b0;
            cnt   <= CW'(LAT - 1);
        end else if (!rdy) begin
            if (cnt == '0) begin
                rdy <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/osc_xtal_startup.sv
module osc_xtal_startup
    import osc_pkg::*;
#(
    parameter int SUT_W      = DEF_SUT_W,
    parameter int UNIT_SHIFT = DEF_UNIT_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xtal_en,
    input  logic             start_ok,
    input  logic [SUT_W-1:0] sut,
    output logic             stable
);
    localparam int CW = SUT_W + UNIT_SHIFT;

    logic          armed;
    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;

    assign load_val = {sut, {UNIT_SHIFT{1'b0}}} - CW'(1);

    always_ff @(posedge clk) begin
        if (rst || !xtal_en) begin
            armed  <= 1'b0;
            stable <= 1'b0;
            cnt    <= '0;
        end else if (!armed) begin
            if (start_ok) begin
                armed <= 1'b1;
                if (sut == '0) begin
                    stable <= 1'b1;
                end else begin
                    cnt <= load_val;
                end
            end
        end else if (!stable) begin
            if (cnt == '0) begin
                stable <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/osc_presence_det.sv
module osc_presence_det
    import osc_pkg::*;
#(
    parameter int WIN  = DEF_WIN,
    parameter int NEED = DEF_NEED,
    parameter int SYNC = DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic xclk,
    input  logic xtal_en,
    input  logic stable,
    input  logic sel_q,
    output logic ok
);
    localparam int WCW = cnt_w(WIN);
    localparam int ECW = $clog2(WIN + 1) + 1;

    logic            tog;
    logic [SYNC:0]   chain;
    logic            pulse;
    det_state_t      state;
    logic [WCW-1:0]  wcnt;
    logic [ECW-1:0]  ecnt;
    logic [ECW-1:0]  ecnt_nx;

    // Toggle on every crystal rising edge
    always_ff @(posedge xclk) begin
        if (rst) begin
            tog <= 1'b0;
        end else begin
            tog <= ~tog;
        end
    end

    // Synchronizer stages plus one history stage
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[SYNC-1:0], tog};
        end
    end

    assign pulse   = chain[SYNC] ^ chain[SYNC-1];
    assign ecnt_nx = ecnt + ECW'(pulse);

    always_ff @(posedge clk) begin
        if (rst || !xtal_en) begin
            state <= DET_IDLE;
            ok    <= 1'b0;
            wcnt  <= '0;
            ecnt  <= '0;
        end else begin
            case (state)
                DET_IDLE: begin
                    if (sel_q && stable) begin
                        state <= DET_WINDOW;
                        wcnt  <= '0;
                        ecnt  <= '0;
                    end
                end
                DET_WINDOW: begin
                    if (!sel_q) begin
                        state <= DET_IDLE;
                    end else begin
                        ecnt <= ecnt_nx;
                        if (wcnt == WCW'(WIN - 1)) begin
                            state <= DET_DONE;
                            ok    <= (ecnt_nx >= ECW'(NEED));
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                end
                DET_DONE: begin
                    if (!sel_q) begin
                        state <= DET_IDLE;
                        ok    <= 1'b0;
                    end
                end
                default: state <= DET_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/osc_clk_mux.sv
module osc_clk_mux (
    input  logic rst,
    input  logic want_x,
    input  logic rc_clk,
    input  logic xclk,
    output logic main_clk,
    output logic x_on,
    output logic r_on
);
    logic x_s1;
    logic r_s1;

    // Crystal side: enable only after the RC side is off
    always_ff @(negedge xclk) begin
        if (rst) begin
            x_s1 <= 1'b0;
            x_on <= 1'b0;
        end else begin
            x_s1 <= want_x & ~r_on;
            x_on <= x_s1;
        end
    end

    // RC side: enable only after the crystal side is off
    always_ff @(negedge rc_clk) begin
        if (rst) begin
            r_s1 <= 1'b1;
            r_on <= 1'b1;
        end else begin
            r_s1 <= ~want_x & ~x_on;
            r_on <= r_s1;
        end
    end

    assign main_clk = (rc_clk & r_on) | (xclk & x_on);

endmodule

// File: rtl/osc_main_switch.sv
module osc_main_switch
    import osc_pkg::*;
#(
    parameter int SUT_W      = DEF_SUT_W,
    parameter int UNIT_SHIFT = DEF_UNIT_SHIFT,
    parameter int MCK_LAT    = DEF_MCK_LAT,
    parameter int WIN        = DEF_WIN,
    parameter int NEED       = DEF_NEED,
    parameter int SYNC       = DEF_SYNC
) (
    input  logic             clk_slow,
    input  logic             rst,
    input  logic             rc_clk,
    input  logic             xtal_clk,
    input  logic             rc_enable,
    input  logic             mck_from_main,
    output logic             mck_ready,
    input  logic             xtal_enable,
    input  logic [SUT_W-1:0] xtal_startup,
    input  logic             src_xtal,
    output logic             xtal_ready,
    output logic             src_xtal_rb,
    output logic             xtal_present,
    output logic             main_clk
);
    logic mck_sel_q;
    logic start_ok;
    logic mux_x_on;
    logic mux_r_on;

    osc_mck_ready #(.LAT(MCK_LAT)) u_mck (
        .clk    (clk_slow),
        .rst    (rst),
        .sel_in (mck_from_main),
        .sel_q  (mck_sel_q),
        .rdy    (mck_ready)
    );

    assign start_ok = rc_enable & ~mck_sel_q & mck_ready;

    osc_xtal_startup #(.SUT_W(SUT_W), .UNIT_SHIFT(UNIT_SHIFT)) u_sut (
        .clk      (clk_slow),
        .rst      (rst),
        .xtal_en  (xtal_enable),
        .start_ok (start_ok),
        .sut      (xtal_startup),
        .stable   (xtal_ready)
    );

    always_ff @(posedge clk_slow) begin
        if (rst) begin
            src_xtal_rb <= 1'b0;
        end else begin
            src_xtal_rb <= src_xtal;
        end
    end

    osc_presence_det #(.WIN(WIN), .NEED(NEED), .SYNC(SYNC)) u_det (
        .clk     (clk_slow),
        .rst     (rst),
        .xclk    (xtal_clk),
        .xtal_en (xtal_enable),
        .stable  (xtal_ready),
        .sel_q   (src_xtal_rb),
        .ok      (xtal_present)
    );

    osc_clk_mux u_mux (
        .rst      (rst),
        .want_x   (xtal_present),
        .rc_clk   (rc_clk),
        .xclk     (xtal_clk),
        .main_clk (main_clk),
        .x_on     (mux_x_on),
        .r_on     (mux_r_on)
    );

endmodule

// File: rtl/osc_main_switch_chk.sv
module osc_main_switch_chk (
    input logic clk_slow,
    input logic rst,
    input logic xtal_enable,
    input logic mck_ready,
    input logic xtal_ready,
    input logic src_xtal_rb,
    input logic xtal_present,
    input logic mux_x_on,
    input logic mux_r_on
);

    // R2
    rdy_low_two_chk: assert property (@(posedge clk_slow) disable iff (rst)
        $fell(mck_ready) |=> !mck_ready);

    // R4
    ready_needs_en_chk: assert property (@(posedge clk_slow) disable iff (rst)
        $rose(xtal_ready) |-> $past(xtal_enable));

    // R6
    present_needs_ready_chk: assert property (@(posedge clk_slow) disable iff (rst)
        xtal_present |-> xtal_ready);

    // R6
    present_rise_sel_chk: assert property (@(posedge clk_slow) disable iff (rst)
        $rose(xtal_present) |-> $past(src_xtal_rb));

    // R9
    disable_clears_chk: assert property (@(posedge clk_slow) disable iff (rst)
        !xtal_enable |=> (!xtal_ready && !xtal_present));

    // R10
    no_overlap_chk: assert property (@(posedge clk_slow) disable iff (rst)
        !(mux_x_on && mux_r_on));

endmodule

bind osc_main_switch osc_main_switch_chk u_chk (
    .clk_slow     (clk_slow),
    .rst          (rst),
    .xtal_enable  (xtal_enable),
    .mck_ready    (mck_ready),
    .xtal_ready   (xtal_ready),
    .src_xtal_rb  (src_xtal_rb),
    .xtal_present (xtal_present),
    .mux_x_on     (mux_x_on),
    .mux_r_on     (mux_r_on)
);

// File: tb/osc_main_switch_tb.sv
module osc_main_switch_tb;
    localparam int SUT_W = 8;

    logic clk_slow = 1'b0;
    logic rst = 1'b1;
    logic rc_clk = 1'b0;
    logic xclk = 1'b0;
    logic rc_enable = 1'b1;
    logic mck_from_main = 1'b0;
    logic xtal_enable = 1'b0;
    logic src_xtal = 1'b0;
    logic [SUT_W-1:0] xtal_startup = '0;
    logic mck_ready, xtal_ready, src_xtal_rb, xtal_present, main_clk;

    int xmode = 1;   // 0 stopped, 1 fast (10 ns), 2 slow (200 ns)
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk_slow = ~clk_slow;   // 125 MHz
    always #7 rc_clk = ~rc_clk;

    // Crystal model: edges only on a 5 ns grid
    initial forever begin
        #5;
        case (xmode)
            0: xclk = 1'b0;
            1: xclk = ~xclk;
            default: if (($time % 100) == 0) xclk = ~xclk;
        endcase
    end

    osc_main_switch #(.SUT_W(SUT_W)) u_dut (
        .clk_slow      (clk_slow),
        .rst           (rst),
        .rc_clk        (rc_clk),
        .xtal_clk      (xclk),
        .rc_enable     (rc_enable),
        .mck_from_main (mck_from_main),
        .mck_ready     (mck_ready),
        .xtal_enable   (xtal_enable),
        .xtal_startup  (xtal_startup),
        .src_xtal      (src_xtal),
        .xtal_ready    (xtal_ready),
        .src_xtal_rb   (src_xtal_rb),
        .xtal_present  (xtal_present),
        .main_clk      (main_clk)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_slow);
        #1;
    endtask

    task automatic at_neg();
        @(negedge clk_slow);
    endtask

    // Compare main_clk with the expected source away from oscillator edges
    task automatic mux_follows(input string req, input bit from_x);
        for (int i = 0; i < 16; i++) begin
            #3;
            if ((($time % 5) != 0) && (($time % 7) != 0))
                chk(req, int'(main_clk), from_x ? int'(xclk) : int'(rc_clk));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_slow);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (10) tick();
        at_neg(); rst = 1'b0;
        tick();
        chk("R1 mck_ready", int'(mck_ready), 1);
        chk("R1 xtal_ready", int'(xtal_ready), 0);
        chk("R1 src_xtal_rb", int'(src_xtal_rb), 0);
        chk("R1 xtal_present", int'(xtal_present), 0);
        mux_follows("R1 main_clk on rc", 1'b0);

        // R2 master clock ready handshake
        at_neg(); mck_from_main = 1'b1;
        tick(); chk("R2 ready after change edge", int'(mck_ready), 0);
        tick(); chk("R2 ready one edge later", int'(mck_ready), 0);
        tick(); chk("R2 ready after latency", int'(mck_ready), 1);

        // R3 start blocked while master clock is on main
        at_neg(); xtal_startup = '0; xtal_enable = 1'b1;
        repeat (20) tick();
        chk("R3 blocked by master select", int'(xtal_ready), 0);
        at_neg(); mck_from_main = 1'b0;
        tick(); tick(); tick();
        chk("R3 waits for master ready", int'(xtal_ready), 0);
        tick();
        chk("R3 accepted after master ready", int'(xtal_ready), 1);
        // R9 clear on disable
        at_neg(); xtal_enable = 1'b0;
        tick(); chk("R9 ready cleared", int'(xtal_ready), 0);
        // R3 start blocked while RC is disabled
        at_neg(); rc_enable = 1'b0; xtal_enable = 1'b1;
        repeat (20) tick();
        chk("R3 blocked by rc disable", int'(xtal_ready), 0);
        at_neg(); rc_enable = 1'b1;
        tick(); chk("R3 accepted with rc on", int'(xtal_ready), 1);

        // R4 startup sweep
        for (int s = 0; s < 12; s++) begin
            int fv;
            fv = (s == 11) ? 255 : s;
            at_neg(); xtal_enable = 1'b0;
            tick(); tick();
            at_neg(); xtal_startup = SUT_W'(fv); xtal_enable = 1'b1;
            for (int k = 1; k <= 8 * fv + 1; k++) begin
                tick();
                if (k == 8 * fv || k == 8 * fv + 1)
                    chk($sformatf("R4 startup %0d edge %0d", fv, k), int'(xtal_ready),
                        (k == 8 * fv + 1) ? 1 : 0);
            end
        end
        at_neg(); xtal_enable = 1'b0;
        tick();
        at_neg(); xtal_startup = '0; xtal_enable = 1'b1;
        tick();

        // R5 R6 detection with a running crystal
        at_neg(); src_xtal = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            tick();
            if (k == 1) chk("R5 readback", int'(src_xtal_rb), 1);
            if (k >= 5) chk($sformatf("R6 present edge %0d", k), int'(xtal_present), (k == 6) ? 1 : 0);
        end
        repeat (10) tick();
        mux_follows("R10 main_clk on crystal", 1'b1);

        // R8 deselect
        at_neg(); src_xtal = 1'b0;
        tick();
        chk("R5 readback cleared", int'(src_xtal_rb), 0);
        chk("R8 present one edge later", int'(xtal_present), 1);
        tick();
        chk("R8 present two edges later", int'(xtal_present), 0);
        repeat (10) tick();
        mux_follows("R10 main_clk back on rc", 1'b0);

        // R7 stopped crystal
        xmode = 0;
        repeat (4) tick();
        at_neg(); src_xtal = 1'b1;
        repeat (6) tick();
        chk("R7 stopped readback", int'(src_xtal_rb), 1);
        chk("R7 stopped present", int'(xtal_present), 0);
        repeat (10) tick();
        mux_follows("R7 main_clk stays on rc", 1'b0);
        at_neg(); src_xtal = 1'b0;
        repeat (3) tick();

        // R7 crystal too slow
        xmode = 2;
        repeat (3) tick();
        at_neg(); src_xtal = 1'b1;
        repeat (6) tick();
        chk("R7 slow readback", int'(src_xtal_rb), 1);
        chk("R7 slow present", int'(xtal_present), 0);
        at_neg(); src_xtal = 1'b0;
        repeat (3) tick();
        xmode = 1;
        repeat (4) tick();

        // R6 select written before the crystal is ready
        at_neg(); xtal_enable = 1'b0;
        tick();
        at_neg(); xtal_startup = SUT_W'(1); xtal_enable = 1'b1; src_xtal = 1'b1;
        for (int k = 1; k <= 14; k++) begin
            tick();
            if (k == 9) chk("R4 ready with early select", int'(xtal_ready), 1);
            if (k == 13) chk("R6 early select edge 13", int'(xtal_present), 0);
            if (k == 14) chk("R6 early select edge 14", int'(xtal_present), 1);
        end

        // R9 disable while present
        at_neg(); xtal_enable = 1'b0;
        tick();
        chk("R9 ready cleared", int'(xtal_ready), 0);
        chk("R9 present cleared", int'(xtal_present), 0);
        chk("R9 readback kept", int'(src_xtal_rb), 1);
        repeat (10) tick();
        mux_follows("R10 main_clk on rc after disable", 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule